// File: doc/BRIEF.md
# Hibernate Wakeup and Reset Sequencer

This block sits in the always-on power domain. It decides when the rest of the chip is powered and when the chip is held in reset. Software asks for power-down by writing to a hibernate control register. The sequencer then drops its power-enable output and waits for the external wakeup input. That input must be sampled high on a programmable number of consecutive RTC ticks before the sequencer accepts it. This filter rejects short glitches on the wakeup line.

Once a wakeup is accepted, power is restored. The system reset output is held low for a programmable number of ticks, then released, and the sequencer returns to normal running. All timing is counted in RTC ticks, which arrive as a single-cycle enable `rtc_tick` on the block clock. The filter length and the reset length are held in masked register fields. Register bits outside those fields are discarded when written.

The sequencer has four named states, each with its own output values:

| State | Power enable | Reset output |
|---|---|---|
| SEQ_RUN | high | high |
| SEQ_SLEEP (hibernating) | low | high |
| SEQ_QUALIFY (wakeup filter) | low | high |
| SEQ_RESET (reset pulse) | high | low |

It has these transitions:

- **RUN→SLEEP**: a hibernate request.
- **SLEEP→QUALIFY**: a ticked wakeup sample with a nonzero filter length.
- **SLEEP→RESET**: a ticked wakeup sample with a zero filter length.
- **QUALIFY→SLEEP**: a ticked sample with wakeup low.
- **QUALIFY→RESET**: the filter length has been reached.
- **RESET→RUN**: the reset length has been reached.

Top module: `hib_wake_seq`

## Requirements
- R1: After power-on reset the sequencer is in SEQ_RUN, with `pwr_en`=1 and `sys_rst_n`=1. Both the filter length and the reset length are zero.
- R2: A write to address 0x20 with data bit 0 set moves SEQ_RUN to SEQ_SLEEP at that clock edge, and `pwr_en` goes low. A write to 0x20 with bit 0 clear has no effect. A hibernate write in any state other than SEQ_RUN is also ignored.
- R3: A write to address 0x24 keeps only data bits 15:5. The filter length in ticks is F = wdata & 0xFFE0, and all other bits are discarded.
- R4: A write to address 0x28 keeps only data bits 11:5. The reset length in ticks is Q = wdata & 0x0FE0, and all other bits are discarded.
- R5: Wakeup is accepted on the (F+1)-th consecutive ticked sample with `wake_in` high. With F=0 the first ticked high sample is accepted. With a tick on every cycle, `pwr_en` rises F+1 cycles after `wake_in` rises in SEQ_SLEEP.
- R6: A ticked sample with `wake_in` low during SEQ_QUALIFY returns the sequencer to SEQ_SLEEP, and the filter count restarts from zero.
- R7: After acceptance, `sys_rst_n` stays low for Q+1 ticks while `pwr_en` is high. A reset length of zero still gives one tick of reset low. After that the sequencer enters SEQ_RUN.
- R8: `pwr_en` is low exactly in SEQ_SLEEP and SEQ_QUALIFY. `sys_rst_n` is low only in SEQ_RESET. Without `rtc_tick`, no state other than SEQ_RUN advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on domain clock |
| rst_n | input | 1 | Active-low power-on reset |
| rtc_tick | input | 1 | One-cycle RTC tick enable |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| wake_in | input | 1 | Wakeup request pin, active high |
| pwr_en | output | 1 | Power enable for the switched domain |
| sys_rst_n | output | 1 | System reset output, active low |

## Verification
A wrong state or an off-by-one count shows directly at the two outputs. `pwr_en` rises one tick early or late after a wakeup, and the low pulse on `sys_rst_n` is one tick too short or too long. Because of this, the bench measures both durations in cycles and compares them with F+1 and Q+1.

A filter count that fails to restart after a glitch shows as an early power-up. A register field that latches stray bits shows as a duration that is a few cycles off. Every such fault appears within the one hibernate and wakeup round that exercises it.

// File: rtl/hws_pkg.sv
package hws_pkg;
    typedef enum logic [1:0] {
        SEQ_RUN     = 2'd0,
        SEQ_SLEEP   = 2'd1,
        SEQ_QUALIFY = 2'd2,
        SEQ_RESET   = 2'd3
    } seq_state_t;

    localparam logic [7:0] ADDR_HIBERNATE = 8'h20;
    localparam logic [7:0] ADDR_FILTER    = 8'h24;
    localparam logic [7:0] ADDR_RSTLEN    = 8'h28;
endpackage

// File: rtl/hws_regs.sv
module hws_regs #(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32,
    parameter int FILT_LO = 5,
    parameter int FILT_HI = 15,
    parameter int RST_LO  = 5,
    parameter int RST_HI  = 11,
    parameter int CNT_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic              hib_req,
    output logic [CNT_W-1:0]  filt_len,
    output logic [CNT_W-1:0]  rst_len
);
    import hws_pkg::*;

    localparam int FW = FILT_HI - FILT_LO + 1;
    localparam int RW = RST_HI - RST_LO + 1;

    logic [FW-1:0] filt_field;
    logic [RW-1:0] rst_field;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            filt_field <= '0;
            rst_field  <= '0;
        end else if (reg_wr) begin
            if (reg_addr == ADDR_W'(ADDR_FILTER))
                filt_field <= reg_wdata[FILT_HI:FILT_LO];
            if (reg_addr == ADDR_W'(ADDR_RSTLEN))
                rst_field <= reg_wdata[RST_HI:RST_LO];
        end
    end

    assign hib_req = reg_wr && (reg_addr == ADDR_W'(ADDR_HIBERNATE)) && reg_wdata[0];

    // Widen each field back into a tick count, with zeros in the discarded low bits.
    generate
        if (FILT_LO > 0) begin : g_filt_lo
            assign filt_len = CNT_W'({filt_field, {FILT_LO{1'b0}}});
        end else begin : g_filt_nolo
            assign filt_len = CNT_W'(filt_field);
        end
        if (RST_LO > 0) begin : g_rst_lo
            assign rst_len = CNT_W'({rst_field, {RST_LO{1'b0}}});
        end else begin : g_rst_nolo
            assign rst_len = CNT_W'(rst_field);
        end
    endgenerate

    assert_filter_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_W'(ADDR_FILTER)) |=> (filt_field == $past(reg_wdata[FILT_HI:FILT_LO])));
    assert_rstlen_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_W'(ADDR_RSTLEN)) |=> (rst_field == $past(reg_wdata[RST_HI:RST_LO])));
    assert_fields_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr |=> ($stable(filt_field) && $stable(rst_field)));
endmodule

// File: rtl/hws_tick_counter.sv
module hws_tick_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   count <= '0;
        else if (clr) count <= '0;
        else if (inc) count <= count + 1'b1;
    end

    assert_count_steps_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && inc) |=> (count == $past(count) + 1'b1));
    assert_count_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !inc) |=> $stable(count));
endmodule

// File: rtl/hws_fsm.sv
module hws_fsm #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rtc_tick,
    input  logic             hib_req,
    input  logic             wake_in,
    input  logic [CNT_W-1:0] filt_len,
    input  logic [CNT_W-1:0] rst_len,
    input  logic [CNT_W-1:0] count,
    output logic             cnt_clr,
    output logic             cnt_inc,
    output logic             pwr_en,
    output logic             sys_rst_n
);
    import hws_pkg::*;

    seq_state_t state, state_nx;
    logic       filt_hit;
    logic       rst_hit;

    assign filt_hit = (count + 1'b1) == filt_len;
    assign rst_hit  = count == rst_len;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SEQ_RUN;
        else        state <= state_nx;
    end

    // Next state and counter control
    always_comb begin
        state_nx = state;
        cnt_clr  = 1'b0;
        cnt_inc  = 1'b0;
        unique case (state)
            SEQ_RUN: begin
                cnt_clr = 1'b1;
                if (hib_req) state_nx = SEQ_SLEEP;
            end
            SEQ_SLEEP: begin
                cnt_clr = 1'b1;
                if (rtc_tick && wake_in)
                    state_nx = (filt_len == '0) ? SEQ_RESET : SEQ_QUALIFY;
            end
            SEQ_QUALIFY: begin
                if (rtc_tick) begin
                    if (!wake_in) begin
                        state_nx = SEQ_SLEEP;
                        cnt_clr  = 1'b1;
                    end else if (filt_hit) begin
                        state_nx = SEQ_RESET;
                        cnt_clr  = 1'b1;
                    end else begin
                        cnt_inc = 1'b1;
                    end
                end
            end
            SEQ_RESET: begin
                if (rtc_tick) begin
                    if (rst_hit) begin
                        state_nx = SEQ_RUN;
                        cnt_clr  = 1'b1;
                    end else begin
                        cnt_inc = 1'b1;
                    end
                end
            end
            default: state_nx = SEQ_RUN;
        endcase
    end

    // Outputs, decoded from the state
    always_comb begin
        pwr_en    = 1'b1;
        sys_rst_n = 1'b1;
        unique case (state)
            SEQ_RUN:     ;
            SEQ_SLEEP:   pwr_en = 1'b0;
            SEQ_QUALIFY: pwr_en = 1'b0;
            SEQ_RESET:   sys_rst_n = 1'b0;
            default:     ;
        endcase
    end

    assert_run_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_RUN && !hib_req) |=> (state == SEQ_RUN));
    assert_sleep_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_RUN && hib_req) |=> (state == SEQ_SLEEP && !pwr_en));
    assert_zero_filter_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_SLEEP && rtc_tick && wake_in && filt_len == '0) |=> (state == SEQ_RESET));
    assert_glitch_back_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_QUALIFY && rtc_tick && !wake_in) |=> (state == SEQ_SLEEP));
    assert_no_tick_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state != SEQ_RUN && !rtc_tick) |=> $stable(state));
    assert_reset_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_RESET && $fell(sys_rst_n)) |-> (count == '0));
    assert_sleep_no_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_SLEEP || state == SEQ_QUALIFY) |=> (state != SEQ_RUN));
endmodule

// File: rtl/hib_wake_seq.sv
module hib_wake_seq #(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32,
    parameter int FILT_LO = 5,
    parameter int FILT_HI = 15,
    parameter int RST_LO  = 5,
    parameter int RST_HI  = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rtc_tick,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              wake_in,
    output logic              pwr_en,
    output logic              sys_rst_n
);
    localparam int CNT_W = ((FILT_HI > RST_HI) ? FILT_HI : RST_HI) + 1;

    logic             hib_req;
    logic [CNT_W-1:0] filt_len;
    logic [CNT_W-1:0] rst_len;
    logic [CNT_W-1:0] count;
    logic             cnt_clr;
    logic             cnt_inc;

    hws_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .FILT_LO(FILT_LO), .FILT_HI(FILT_HI),
        .RST_LO(RST_LO), .RST_HI(RST_HI), .CNT_W(CNT_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .hib_req(hib_req),
        .filt_len(filt_len), .rst_len(rst_len)
    );

    hws_tick_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(cnt_inc), .count(count)
    );

    hws_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .rtc_tick(rtc_tick), .hib_req(hib_req),
        .wake_in(wake_in), .filt_len(filt_len), .rst_len(rst_len),
        .count(count), .cnt_clr(cnt_clr), .cnt_inc(cnt_inc),
        .pwr_en(pwr_en), .sys_rst_n(sys_rst_n)
    );

    assert_off_not_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_en |-> sys_rst_n);
endmodule

// File: tb/hib_wake_seq_test.sv
module hib_wake_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rtc_tick = 1'b1;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        wake_in = 1'b0;
    logic        pwr_en;
    logic        sys_rst_n;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    hib_wake_seq uut (
        .clk(clk), .rst_n(rst_n), .rtc_tick(rtc_tick), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .wake_in(wake_in),
        .pwr_en(pwr_en), .sys_rst_n(sys_rst_n)
    );

    task automatic check(input string req, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    // Enter hibernate, raise wake, return the cycles until power-up and the reset-low cycles.
    task automatic round(output int n_up, output int n_rst);
        wr(8'h20, 32'h1);
        wake_in = 1'b1;
        n_up = 0;
        do begin @(negedge clk); n_up++; end while (!pwr_en && n_up < 70000);
        n_rst = 0;
        while (!sys_rst_n && n_rst < 5000) begin n_rst++; @(negedge clk); end
        wake_in = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        int up, rl;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 pwr_en after reset", pwr_en, 1);
        check("R1 sys_rst_n after reset", sys_rst_n, 1);
        round(up, rl);
        check("R1 zero filter default", up, 1);
        check("R1 zero reset default", rl, 1);

        // R2: a hibernate write with bit 0 clear is ignored
        wr(8'h20, 32'hFFFF_FFFE);
        repeat (5) @(negedge clk);
        check("R2 bit0 clear ignored", pwr_en, 1);

        // R3 R4 R5 R7: sweep of field values, with stray bits set outside the fields
        for (int f = 0; f < 4; f++) begin
            for (int q = 0; q < 4; q++) begin
                wr(8'h24, (f << 5) | 32'hFFFF_001F);
                wr(8'h28, (q << 5) | 32'hFFFF_F01F);
                round(up, rl);
                check("R5 R3 filter length", up, f * 32 + 1);
                check("R7 R4 reset length", rl, q * 32 + 1);
            end
        end

        // R3 R4: maximum field values
        wr(8'h24, 32'hFFFF_FFFF);
        wr(8'h28, 32'hFFFF_FFFF);
        round(up, rl);
        check("R3 max filter", up, 65504 + 1);
        check("R4 max reset", rl, 4064 + 1);

        // R6: a glitch during the filter restarts the count
        wr(8'h24, 32'h40);
        wr(8'h28, 32'h0);
        wr(8'h20, 32'h1);
        wake_in = 1'b1;
        repeat (30) @(negedge clk);
        wake_in = 1'b0;
        repeat (10) @(negedge clk);
        check("R6 glitch keeps power off", pwr_en, 0);
        wake_in = 1'b1;
        up = 0;
        do begin @(negedge clk); up++; end while (!pwr_en && up < 1000);
        check("R6 filter restarted", up, 65);
        wake_in = 1'b0;
        repeat (3) @(negedge clk);

        // R8: without ticks nothing advances
        wr(8'h20, 32'h1);
        check("R8 power low in sleep", pwr_en, 0);
        check("R8 reset high in sleep", sys_rst_n, 1);
        rtc_tick = 1'b0;
        wake_in = 1'b1;
        repeat (200) @(negedge clk);
        check("R8 no tick holds sleep", pwr_en, 0);
        rtc_tick = 1'b1;
        up = 0;
        do begin @(negedge clk); up++; end while (!pwr_en && up < 1000);
        check("R8 resumes on ticks", up, 65);

        // R2: a hibernate write during the reset pulse is ignored
        wr(8'h28, 32'h40);
        wake_in = 1'b0;
        repeat (3) @(negedge clk);
        wr(8'h24, 32'h0);
        wr(8'h20, 32'h1);
        wake_in = 1'b1;
        @(negedge clk);
        check("R7 in reset pulse", sys_rst_n, 0);
        wake_in = 1'b0;
        wr(8'h20, 32'h1);
        repeat (100) @(negedge clk);
        check("R2 hibernate ignored in reset: pwr", pwr_en, 1);
        check("R2 hibernate ignored in reset: rst", sys_rst_n, 1);

        finished = 1'b1;
    end

    initial begin
        for (int c = 0; c < 190000 && !finished; c++) @(negedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule